// File: doc/BRIEF.md
# Swappable Accelerator Job Wrapper

This block is the fixed shell around an exchangeable processing core. Software reaches it through a Wishbone slave port. Over that port it sets a source buffer address, a destination buffer address and a word count, and it can also tune the core's own settings through a forwarded configuration window. A single write then launches a job. The wrapper's Wishbone master port then walks the job one word at a time. It fetches a word from the source buffer, hands it to the core, and stores the core's answer in the destination buffer. When the last word is stored, the wrapper raises a completion flag.

The typical sequence has four steps. The host places its input data in memory. It programs the three job registers. It writes the start bit. It then polls the status register, or waits for the interrupt, and reads the results from memory. Four LED outputs mirror the job state so it can be seen while debugging. The core itself is combinational from the wrapper's point of view: it sees the word that was last fetched and returns a result word in the same cycle.

Top module: `accel_shell`

## Requirements
- R1: Every slave request (cyc and stb high) is acknowledged with a single-cycle ack on the clock edge after the request is presented. A write takes effect on that same edge. Read data is valid while ack is high.
- R2: The slave address is decoded on byte address bits [5:2]. 0x00 is the control register: bit 0 starts a job and always reads 0, and bit 1 enables the interrupt. 0x04 is status: bit 0 is busy and bit 1 is done. 0x08 holds the source byte address and 0x0C the destination byte address. 0x10 holds the word count, of which only the low LEN_W bits (16 by default) are kept. The unused offsets 0x14 to 0x1C read as zero.
- R3: The master uses single classic cycles. cyc and stb rise together, and the address, we and data hold steady until ack. The request drops for at least one cycle after each ack.
- R4: A job of N words makes exactly 2N master cycles, strictly alternating: for k = 0 to N-1, a read of SRC+4k and then a write to DST+4k. Memory beyond the destination range is left untouched.
- R5: The data of each master write equals the core output produced for the word fetched by the preceding read.
- R6: A start write while idle with a nonzero count sets busy and clears done on the edge of its ack. The ack of the last write clears busy and sets done on the same edge.
- R7: A start with a count of zero sets done on the edge of its ack. Busy never rises and no master cycle is issued. The master cyc is never high while busy is low.
- R8: A start write while busy is ignored. Writes to the source, destination or count registers during a job update those registers but do not change the running job.
- R9: Writing status with bit 1 set clears done. Writing status with bit 1 clear leaves done unchanged.
- R10: irq_o is high exactly when done is set and the interrupt enable bit is set.
- R11: Slave accesses at 0x20 to 0x3F go to the core's configuration port. A write gives a one-cycle core_cfg_we_o with core_cfg_adr_o = address bits [4:2] and the write data. A read returns core_cfg_dat_i.
- R12: led_o is {done, busy, master write in progress, master read in progress}. Bit 1 is high during a master cycle with we high, and bit 0 during a master cycle with we low.
- R13: After reset, every register is zero, no ack or master cycle is pending, irq_o is low and led_o is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| s_cyc_i | input | 1 | Slave bus cycle |
| s_stb_i | input | 1 | Slave strobe |
| s_we_i | input | 1 | Slave write enable |
| s_adr_i | input | AW | Slave byte address |
| s_dat_i | input | DW | Slave write data |
| s_dat_o | output | DW | Slave read data |
| s_ack_o | output | 1 | Slave acknowledge |
| m_cyc_o | output | 1 | Master bus cycle |
| m_stb_o | output | 1 | Master strobe |
| m_we_o | output | 1 | Master write enable |
| m_adr_o | output | AW | Master byte address |
| m_dat_o | output | DW | Master write data (core result) |
| m_dat_i | input | DW | Master read data |
| m_ack_i | input | 1 | Master acknowledge |
| core_din_o | output | DW | Word last fetched, presented to the core |
| core_dout_i | input | DW | Core result for core_din_o |
| core_cfg_we_o | output | 1 | Core configuration write strobe |
| core_cfg_adr_o | output | CFG_AW | Core configuration register index |
| core_cfg_dat_o | output | DW | Core configuration write data |
| core_cfg_dat_i | input | DW | Core configuration read data |
| irq_o | output | 1 | Job completion interrupt |
| led_o | output | 4 | Debug state for LEDs |

## Verification
On every cycle, the assertions check the handshake rules of both buses. These are the single-cycle slave ack, the master request held until ack and the idle gap after it, and the one-cycle configuration strobe. They also check the job control rules: done follows the fall of busy, a zero count finishes at once, a start while busy leaves the running job as it was, and there is no master traffic without a job. Only the bench's scenarios can show the results of whole jobs. These are the data written to memory, the exact alternating address order, the destination words left unchanged, and the register readback, W1C and interrupt gating. The jobs run at several memory wait-state settings and core configurations.

// File: rtl/accel_shell_pkg.sv
package accel_shell_pkg;

   typedef enum logic [2:0] {
      MV_IDLE,
      MV_RD,
      MV_RD_GAP,
      MV_WR,
      MV_WR_GAP
   } mover_state_e;

   localparam logic [2:0] RIDX_CTRL = 3'd0;
   localparam logic [2:0] RIDX_STAT = 3'd1;
   localparam logic [2:0] RIDX_SRC  = 3'd2;
   localparam logic [2:0] RIDX_DST  = 3'd3;
   localparam logic [2:0] RIDX_LEN  = 3'd4;

   localparam int CTRL_START_BIT = 0;
   localparam int CTRL_IRQEN_BIT = 1;
   localparam int STAT_BUSY_BIT  = 0;
   localparam int STAT_DONE_BIT  = 1;

endpackage

// File: rtl/accel_regs.sv
module accel_regs
   import accel_shell_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int LEN_W   = 16,
   parameter int CFG_AW  = 3,
   parameter bit HAS_CFG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              s_cyc_i,
   input  logic              s_stb_i,
   input  logic              s_we_i,
   input  logic [AW-1:0]     s_adr_i,
   input  logic [DW-1:0]     s_dat_i,
   output logic [DW-1:0]     s_dat_o,
   output logic              s_ack_o,
   input  logic              busy_i,
   input  logic              done_i,
   output logic              start_o,
   output logic              done_clr_o,
   output logic              irq_en_o,
   output logic [AW-1:0]     src_o,
   output logic [AW-1:0]     dst_o,
   output logic [LEN_W-1:0]  len_o,
   output logic              cfg_we_o,
   output logic [CFG_AW-1:0] cfg_adr_o,
   output logic [DW-1:0]     cfg_dat_o,
   input  logic [DW-1:0]     cfg_dat_i
);

   localparam int WIN_BIT = CFG_AW + 2;

   logic              ack_q;
   logic [DW-1:0]     rdata_q;
   logic              irq_en_q;
   logic [AW-1:0]     src_q;
   logic [AW-1:0]     dst_q;
   logic [LEN_W-1:0]  len_q;

   logic              req;
   logic              wr;
   logic              in_win;
   logic [2:0]        ridx;
   logic [DW-1:0]     ctl_rdata;
   logic [DW-1:0]     win_rdata;

   assign req  = s_cyc_i & s_stb_i & ~ack_q;
   assign wr   = req & s_we_i;
   assign ridx = s_adr_i[4:2];

   generate
      if (HAS_CFG) begin : g_cfg
         logic unused_adr_bits;
         assign in_win    = s_adr_i[WIN_BIT];
         assign cfg_we_o  = wr & in_win;
         assign cfg_adr_o = s_adr_i[WIN_BIT-1:2];
         assign cfg_dat_o = s_dat_i;
         assign win_rdata = cfg_dat_i;
         assign unused_adr_bits = ^{s_adr_i[AW-1:WIN_BIT+1], s_adr_i[1:0]};
      end else begin : g_nocfg
         logic unused_cfg_bits;
         assign in_win    = 1'b0;
         assign cfg_we_o  = 1'b0;
         assign cfg_adr_o = '0;
         assign cfg_dat_o = '0;
         assign win_rdata = '0;
         assign unused_cfg_bits = ^{cfg_dat_i, s_adr_i[AW-1:5], s_adr_i[1:0]};
      end
   endgenerate

   assign start_o    = wr & ~in_win & (ridx == RIDX_CTRL) & s_dat_i[CTRL_START_BIT];
   assign done_clr_o = wr & ~in_win & (ridx == RIDX_STAT) & s_dat_i[STAT_DONE_BIT];

   always_comb begin
      ctl_rdata = '0;
      case (ridx)
         RIDX_CTRL: ctl_rdata[CTRL_IRQEN_BIT] = irq_en_q;
         RIDX_STAT: begin
            ctl_rdata[STAT_BUSY_BIT] = busy_i;
            ctl_rdata[STAT_DONE_BIT] = done_i;
         end
         RIDX_SRC:  ctl_rdata[AW-1:0]    = src_q;
         RIDX_DST:  ctl_rdata[AW-1:0]    = dst_q;
         RIDX_LEN:  ctl_rdata[LEN_W-1:0] = len_q;
         default:   ctl_rdata = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ack_q    <= 1'b0;
         rdata_q  <= '0;
         irq_en_q <= 1'b0;
         src_q    <= '0;
         dst_q    <= '0;
         len_q    <= '0;
      end else begin
         ack_q <= req;
         if (req) begin
            rdata_q <= in_win ? win_rdata : ctl_rdata;
         end
         if (wr && !in_win) begin
            case (ridx)
               RIDX_CTRL: irq_en_q <= s_dat_i[CTRL_IRQEN_BIT];
               RIDX_SRC:  src_q    <= s_dat_i[AW-1:0];
               RIDX_DST:  dst_q    <= s_dat_i[AW-1:0];
               RIDX_LEN:  len_q    <= s_dat_i[LEN_W-1:0];
               default:   ;
            endcase
         end
      end
   end

   assign s_ack_o  = ack_q;
   assign s_dat_o  = rdata_q;
   assign irq_en_o = irq_en_q;
   assign src_o    = src_q;
   assign dst_o    = dst_q;
   assign len_o    = len_q;

   // R1: slave acknowledge never lasts longer than one cycle
   assert_ack_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_ack_o |=> !s_ack_o);

   // R11: configuration strobe is a single-cycle pulse
   assert_cfg_we_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_we_o |=> !cfg_we_o);

endmodule

// File: rtl/accel_seq.sv
module accel_seq #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int LEN_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             done_clr_i,
   input  logic [AW-1:0]    src_i,
   input  logic [AW-1:0]    dst_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             word_done_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [AW-1:0]    rd_ptr_o,
   output logic [AW-1:0]    wr_ptr_o
);

   localparam int STEP = DW / 8;

   logic             busy_q;
   logic             done_q;
   logic [AW-1:0]    rd_ptr_q;
   logic [AW-1:0]    wr_ptr_q;
   logic [LEN_W-1:0] remain_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         remain_q <= '0;
      end else begin
         if (done_clr_i) begin
            done_q <= 1'b0;
         end
         if (start_i && !busy_q) begin
            rd_ptr_q <= src_i;
            wr_ptr_q <= dst_i;
            remain_q <= len_i;
            if (len_i == '0) begin
               done_q <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               done_q <= 1'b0;
            end
         end else if (busy_q && word_done_i) begin
            rd_ptr_q <= rd_ptr_q + AW'(STEP);
            wr_ptr_q <= wr_ptr_q + AW'(STEP);
            remain_q <= remain_q - LEN_W'(1);
            if (remain_q == LEN_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign rd_ptr_o = rd_ptr_q;
   assign wr_ptr_o = wr_ptr_q;

   // R6: a job that ends always leaves done set
   assert_done_on_finish_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_q) |-> done_q);

   // R7: zero-length start completes at once without becoming busy
   assert_zero_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_q && (len_i == '0)) |=> (done_q && !busy_q));

   // R8: a start during a job leaves its progress untouched
   assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && busy_q && !word_done_i) |=>
         (busy_q && $stable(rd_ptr_q) && $stable(wr_ptr_q) && $stable(remain_q)));

endmodule

// File: rtl/accel_mover.sv
module accel_mover
   import accel_shell_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          busy_i,
   input  logic [AW-1:0] rd_ptr_i,
   input  logic [AW-1:0] wr_ptr_i,
   output logic          m_cyc_o,
   output logic          m_stb_o,
   output logic          m_we_o,
   output logic [AW-1:0] m_adr_o,
   output logic [DW-1:0] m_dat_o,
   input  logic [DW-1:0] m_dat_i,
   input  logic          m_ack_i,
   output logic [DW-1:0] core_din_o,
   input  logic [DW-1:0] core_dout_i,
   output logic          word_done_o,
   output logic          phase_rd_o,
   output logic          phase_wr_o
);

   mover_state_e state_q;
   logic [DW-1:0] fetched_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q   <= MV_IDLE;
         fetched_q <= '0;
      end else begin
         case (state_q)
            MV_IDLE:   if (busy_i) state_q <= MV_RD;
            MV_RD: begin
               if (m_ack_i) begin
                  fetched_q <= m_dat_i;
                  state_q   <= MV_RD_GAP;
               end
            end
            MV_RD_GAP: state_q <= MV_WR;
            MV_WR:     if (m_ack_i) state_q <= MV_WR_GAP;
            MV_WR_GAP: state_q <= busy_i ? MV_RD : MV_IDLE;
            default:   state_q <= MV_IDLE;
         endcase
      end
   end

   assign phase_rd_o  = (state_q == MV_RD);
   assign phase_wr_o  = (state_q == MV_WR);
   assign m_cyc_o     = phase_rd_o | phase_wr_o;
   assign m_stb_o     = phase_rd_o | phase_wr_o;
   assign m_we_o      = phase_wr_o;
   assign m_adr_o     = phase_wr_o ? wr_ptr_i : rd_ptr_i;
   assign m_dat_o     = core_dout_i;
   assign core_din_o  = fetched_q;
   assign word_done_o = phase_wr_o & m_ack_i;

   // R3: strobe only inside a cycle
   assert_stb_in_cyc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_stb_o |-> m_cyc_o);

   // R3: an unanswered request keeps its address and direction
   assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_stb_o && !m_ack_i) |=> (m_stb_o && $stable(m_adr_o) && $stable(m_we_o)));

   // R3: each acknowledged cycle is followed by an idle cycle
   assert_gap_after_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_stb_o && m_ack_i) |=> !m_cyc_o);

endmodule

// File: rtl/accel_shell.sv
module accel_shell #(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int LEN_W   = 16,
   parameter int CFG_AW  = 3,
   parameter bit HAS_CFG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              s_cyc_i,
   input  logic              s_stb_i,
   input  logic              s_we_i,
   input  logic [AW-1:0]     s_adr_i,
   input  logic [DW-1:0]     s_dat_i,
   output logic [DW-1:0]     s_dat_o,
   output logic              s_ack_o,
   output logic              m_cyc_o,
   output logic              m_stb_o,
   output logic              m_we_o,
   output logic [AW-1:0]     m_adr_o,
   output logic [DW-1:0]     m_dat_o,
   input  logic [DW-1:0]     m_dat_i,
   input  logic              m_ack_i,
   output logic [DW-1:0]     core_din_o,
   input  logic [DW-1:0]     core_dout_i,
   output logic              core_cfg_we_o,
   output logic [CFG_AW-1:0] core_cfg_adr_o,
   output logic [DW-1:0]     core_cfg_dat_o,
   input  logic [DW-1:0]     core_cfg_dat_i,
   output logic              irq_o,
   output logic [3:0]        led_o
);

   generate
      if ((DW < AW) || (DW < LEN_W) || ((DW % 8) != 0) || (CFG_AW < 3) ||
          (AW <= CFG_AW + 3) || (LEN_W < 1)) begin : g_bad_params
         $error("accel_shell: inconsistent width parameters");
      end
   endgenerate

   logic             start;
   logic             done_clr;
   logic             irq_en;
   logic [AW-1:0]    src;
   logic [AW-1:0]    dst;
   logic [LEN_W-1:0] len;
   logic             busy;
   logic             done;
   logic [AW-1:0]    rd_ptr;
   logic [AW-1:0]    wr_ptr;
   logic             word_done;
   logic             phase_rd;
   logic             phase_wr;

   accel_regs #(
      .AW(AW), .DW(DW), .LEN_W(LEN_W), .CFG_AW(CFG_AW), .HAS_CFG(HAS_CFG)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .s_cyc_i    (s_cyc_i),
      .s_stb_i    (s_stb_i),
      .s_we_i     (s_we_i),
      .s_adr_i    (s_adr_i),
      .s_dat_i    (s_dat_i),
      .s_dat_o    (s_dat_o),
      .s_ack_o    (s_ack_o),
      .busy_i     (busy),
      .done_i     (done),
      .start_o    (start),
      .done_clr_o (done_clr),
      .irq_en_o   (irq_en),
      .src_o      (src),
      .dst_o      (dst),
      .len_o      (len),
      .cfg_we_o   (core_cfg_we_o),
      .cfg_adr_o  (core_cfg_adr_o),
      .cfg_dat_o  (core_cfg_dat_o),
      .cfg_dat_i  (core_cfg_dat_i)
   );

   accel_seq #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start),
      .done_clr_i  (done_clr),
      .src_i       (src),
      .dst_i       (dst),
      .len_i       (len),
      .word_done_i (word_done),
      .busy_o      (busy),
      .done_o      (done),
      .rd_ptr_o    (rd_ptr),
      .wr_ptr_o    (wr_ptr)
   );

   accel_mover #(.AW(AW), .DW(DW)) u_mover (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .busy_i      (busy),
      .rd_ptr_i    (rd_ptr),
      .wr_ptr_i    (wr_ptr),
      .m_cyc_o     (m_cyc_o),
      .m_stb_o     (m_stb_o),
      .m_we_o      (m_we_o),
      .m_adr_o     (m_adr_o),
      .m_dat_o     (m_dat_o),
      .m_dat_i     (m_dat_i),
      .m_ack_i     (m_ack_i),
      .core_din_o  (core_din_o),
      .core_dout_i (core_dout_i),
      .word_done_o (word_done),
      .phase_rd_o  (phase_rd),
      .phase_wr_o  (phase_wr)
   );

   assign irq_o = done & irq_en;
   assign led_o = {done, busy, phase_wr, phase_rd};

   // R7: no master traffic outside a job
   assert_no_traffic_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy |-> !m_cyc_o);

endmodule

// File: tb/tb_accel_shell.sv
`timescale 1ns/1ps
module tb_accel_shell;

   localparam logic [31:0] A_CTRL = 32'h00;
   localparam logic [31:0] A_STAT = 32'h04;
   localparam logic [31:0] A_SRC  = 32'h08;
   localparam logic [31:0] A_DST  = 32'h0C;
   localparam logic [31:0] A_LEN  = 32'h10;

   localparam int NV = 4;
   localparam logic [31:0] V_SRC [NV] = '{32'h000, 32'h040, 32'h0A0, 32'h080};
   localparam logic [31:0] V_DST [NV] = '{32'h200, 32'h300, 32'h380, 32'h2C0};
   localparam logic [31:0] V_LEN [NV] = '{32'd1, 32'd5, 32'd8, 32'd3};
   localparam logic [31:0] V_C0  [NV] = '{32'h0, 32'h7, 32'h100, 32'h1};
   localparam logic [31:0] V_C1  [NV] = '{32'h0, 32'hFF, 32'h5A5A5A5A, 32'h0};
   localparam int          V_LAT [NV] = '{0, 2, 1, 3};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_cyc = 1'b0, s_stb = 1'b0, s_we = 1'b0;
   logic [31:0] s_adr = '0, s_dati = '0;
   logic [31:0] s_dato;
   logic        s_ack;
   logic        m_cyc, m_stb, m_we, m_ack;
   logic [31:0] m_adr, m_dato, m_dati;
   logic [31:0] core_din, core_dout;
   logic        cfg_we;
   logic [2:0]  cfg_adr;
   logic [31:0] cfg_dato, cfg_dati;
   logic        irq;
   logic [3:0]  led;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   accel_shell dut (
      .clk_i(clk), .rst_ni(rst_n),
      .s_cyc_i(s_cyc), .s_stb_i(s_stb), .s_we_i(s_we), .s_adr_i(s_adr),
      .s_dat_i(s_dati), .s_dat_o(s_dato), .s_ack_o(s_ack),
      .m_cyc_o(m_cyc), .m_stb_o(m_stb), .m_we_o(m_we), .m_adr_o(m_adr),
      .m_dat_o(m_dato), .m_dat_i(m_dati), .m_ack_i(m_ack),
      .core_din_o(core_din), .core_dout_i(core_dout),
      .core_cfg_we_o(cfg_we), .core_cfg_adr_o(cfg_adr),
      .core_cfg_dat_o(cfg_dato), .core_cfg_dat_i(cfg_dati),
      .irq_o(irq), .led_o(led)
   );

   // core model: result = (word ^ cfg1) + cfg0
   logic [31:0] cfg_m [0:7];
   initial for (int i = 0; i < 8; i++) cfg_m[i] = '0;
   always @(posedge clk) if (cfg_we) cfg_m[cfg_adr] <= cfg_dato;
   assign cfg_dati  = cfg_m[cfg_adr];
   assign core_dout = (core_din ^ cfg_m[1]) + cfg_m[0];

   // memory model with programmable wait states and a transfer log
   logic [31:0] mem [0:255];
   logic [31:0] log_adr [0:63];
   logic        log_we [0:63];
   int          log_n = 0;
   int          mem_lat = 0;
   int          wcnt = 0;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdat = '0;
   logic        cyc_seen = 1'b0;
   int          led_bad = 0;

   assign m_ack  = mem_ack;
   assign m_dati = mem_rdat;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         wcnt    <= 0;
      end else if (m_cyc && m_stb && !mem_ack) begin
         if (wcnt < mem_lat) wcnt <= wcnt + 1;
         else begin
            wcnt    <= 0;
            mem_ack <= 1'b1;
            if (m_we) mem[m_adr[9:2]] <= m_dato;
            else      mem_rdat <= mem[m_adr[9:2]];
            if (log_n < 64) begin
               log_adr[log_n] <= m_adr;
               log_we[log_n]  <= m_we;
            end
            log_n <= log_n + 1;
         end
      end else mem_ack <= 1'b0;
      if (m_cyc) cyc_seen <= 1'b1;
   end

   // R12 monitor: LED phase bits against observed bus direction
   always @(negedge clk) begin
      if (rst_n && (led[1:0] != {m_cyc & m_we, m_cyc & ~m_we})) led_bad <= led_bad + 1;
   end

   function automatic logic [31:0] init_word(input int i);
      return 32'h0A0B0000 + (32'(i) * 32'h00010003);
   endfunction

   task automatic init_mem();
      for (int i = 0; i < 256; i++) mem[i] = init_word(i);
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic sw(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      s_cyc = 1'b1; s_stb = 1'b1; s_we = 1'b1; s_adr = a; s_dati = d;
      @(negedge clk);
      s_cyc = 1'b0; s_stb = 1'b0; s_we = 1'b0;
   endtask

   task automatic sr(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      s_cyc = 1'b1; s_stb = 1'b1; s_we = 1'b0; s_adr = a;
      @(negedge clk);
      d = s_dato;
      s_cyc = 1'b0; s_stb = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      logic [31:0] st;
      st = '0;
      for (int i = 0; i < 400; i++) begin
         sr(A_STAT, st);
         if (st[1]) break;
      end
      check(st[1] == 1'b1, tag, st, 32'h2);
   endtask

   function automatic logic [31:0] core_f(input logic [31:0] x, input logic [31:0] c0, input logic [31:0] c1);
      return (x ^ c1) + c0;
   endfunction

   task automatic check_job(input logic [31:0] src, input logic [31:0] dst, input int len,
                            input logic [31:0] c0, input logic [31:0] c1);
      int mism;
      int bad_order;
      mism = 0;
      bad_order = 0;
      for (int k = 0; k < len; k++)
         if (mem[dst[9:2] + 8'(k)] !== core_f(init_word(int'(src[9:2]) + k), c0, c1)) mism++;
      check(mism == 0, "R5 result words", 32'(mism), 32'd0);
      if (log_n != 2 * len) bad_order++;
      else
         for (int k = 0; k < len; k++) begin
            if (log_we[2*k] !== 1'b0 || log_adr[2*k] !== src + 32'(4*k)) bad_order++;
            if (log_we[2*k+1] !== 1'b1 || log_adr[2*k+1] !== dst + 32'(4*k)) bad_order++;
         end
      check(bad_order == 0, "R4 transfer order", 32'(log_n), 32'(2*len));
      check(mem[dst[9:2] + 8'(len)] === init_word(int'(dst[9:2]) + len), "R4 beyond destination",
            mem[dst[9:2] + 8'(len)], init_word(int'(dst[9:2]) + len));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R6: got %h expected %h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      init_mem();
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R13 reset state
      check({s_ack, m_cyc, irq} == 3'b000, "R13 ack/cyc/irq after reset", {29'd0, s_ack, m_cyc, irq}, 32'd0);
      check(led == 4'b0000, "R13 led after reset", {28'd0, led}, 32'd0);
      sr(A_SRC, rd);  check(rd == 32'd0, "R13 SRC reset", rd, 32'd0);
      sr(A_LEN, rd);  check(rd == 32'd0, "R13 LEN reset", rd, 32'd0);

      // R1 ack timing
      @(negedge clk);
      s_cyc = 1'b1; s_stb = 1'b1; s_we = 1'b0; s_adr = A_STAT;
      check(s_ack == 1'b0, "R1 no ack before edge", {31'd0, s_ack}, 32'd0);
      @(negedge clk);
      check(s_ack == 1'b1, "R1 ack after one edge", {31'd0, s_ack}, 32'd1);
      s_cyc = 1'b0; s_stb = 1'b0;
      @(negedge clk);
      check(s_ack == 1'b0, "R1 ack single cycle", {31'd0, s_ack}, 32'd0);

      // R2 register map
      sw(A_SRC, 32'hDEADBEEC); sr(A_SRC, rd); check(rd == 32'hDEADBEEC, "R2 SRC readback", rd, 32'hDEADBEEC);
      sw(A_LEN, 32'hFFFF1234); sr(A_LEN, rd); check(rd == 32'h00001234, "R2 LEN width", rd, 32'h00001234);
      sw(A_CTRL, 32'h2);       sr(A_CTRL, rd); check(rd == 32'h2, "R2 CTRL readback", rd, 32'h2);
      sr(32'h14, rd);          check(rd == 32'h0, "R2 unmapped offset", rd, 32'h0);

      // R11 configuration window
      sw(32'h2C, 32'hCAFE0123); sr(32'h2C, rd); check(rd == 32'hCAFE0123, "R11 core cfg readback", rd, 32'hCAFE0123);
      check(cfg_m[3] == 32'hCAFE0123, "R11 core cfg index", cfg_m[3], 32'hCAFE0123);

      // vector table: full jobs with varied buffers, counts, core settings, wait states
      for (int v = 0; v < NV; v++) begin
         init_mem();
         log_n = 0;
         mem_lat = V_LAT[v];
         sw(32'h20, V_C0[v]);
         sw(32'h24, V_C1[v]);
         sw(A_SRC, V_SRC[v]);
         sw(A_DST, V_DST[v]);
         sw(A_LEN, V_LEN[v]);
         sw(A_CTRL, 32'h3);
         wait_done("R6 job completes");
         check_job(V_SRC[v], V_DST[v], int'(V_LEN[v]), V_C0[v], V_C1[v]);
         check(irq == 1'b1, "R10 irq when enabled", {31'd0, irq}, 32'd1);
         check(led == 4'b1000, "R12 led when done", {28'd0, led}, 32'h8);
         sw(A_STAT, 32'h2);
      end

      // R9 write-one-to-clear
      init_mem(); log_n = 0; mem_lat = 0;
      sw(32'h20, 32'h0); sw(32'h24, 32'h0);
      sw(A_SRC, 32'h010); sw(A_DST, 32'h210); sw(A_LEN, 32'd2); sw(A_CTRL, 32'h3);
      wait_done("R6 job completes");
      sw(A_STAT, 32'h1); sr(A_STAT, rd); check(rd[1] == 1'b1, "R9 write zero keeps done", rd, 32'h2);
      sw(A_STAT, 32'h2); sr(A_STAT, rd); check(rd[1] == 1'b0, "R9 W1C clears done", rd, 32'h0);
      check(irq == 1'b0, "R10 irq falls with done", {31'd0, irq}, 32'd0);

      // R6 busy on start edge, R8 start and reprogramming during a job ignored
      init_mem(); log_n = 0; mem_lat = 5;
      sw(32'h20, 32'h11); sw(32'h24, 32'h0);
      sw(A_SRC, 32'h040); sw(A_DST, 32'h200); sw(A_LEN, 32'd4); sw(A_CTRL, 32'h1);
      check(led == 4'b0100, "R6 busy with start ack", {28'd0, led}, 32'h4);
      sw(A_SRC, 32'h0); sw(A_DST, 32'h0); sw(A_LEN, 32'd1); sw(A_CTRL, 32'h1);
      wait_done("R8 original job completes");
      check_job(32'h040, 32'h200, 4, 32'h11, 32'h0);
      check(mem[0] == init_word(0), "R8 new DST not written", mem[0], init_word(0));
      check(irq == 1'b0, "R10 irq masked when disabled", {31'd0, irq}, 32'd0);
      sr(A_SRC, rd); check(rd == 32'h0, "R8 register still updated", rd, 32'h0);
      sw(A_STAT, 32'h2);

      // R7 zero count
      repeat (3) @(negedge clk);
      cyc_seen = 1'b0; log_n = 0;
      sw(A_LEN, 32'd0); sw(A_CTRL, 32'h1);
      check(led == 4'b1000, "R7 done at once on zero count", {28'd0, led}, 32'h8);
      repeat (20) @(negedge clk);
      check(cyc_seen == 1'b0 && log_n == 0, "R7 no master traffic", {31'd0, cyc_seen}, 32'd0);
      check(led_bad == 0, "R12 led phase bits", 32'(led_bad), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule